// File: doc/BRIEF.md
# Encode DSP Host Memory Window and Reset Front End

This block sits between a host register bus and an embedded encoding DSP. It occupies a 64 KiB byte-addressed region that is accessed in 32-bit words. Host reads that land in one of three DSP memory spaces (called X, Y and P here) go to that space's read port as a word index. The fetched word comes back on the bus one cycle later. Reads anywhere else return a small scratch register file or the control register.

The host may not write the memory spaces. Such a write is dropped and raises a sticky error flag. The control register holds two release bits, which together let the DSP run. A write that clears either release bit sends a one-cycle reset pulse to the DSP core. A write that sets both release bits, when they were not both set before, sends a one-cycle bootstrap pulse. Two further bits drive the DSP's non-maskable interrupt and abort lines as levels.

Top module: `dsp_mmio_front`

## Requirements
- R1: After reset, core_reset, core_boot, core_run, core_nmi, core_abort and win_wr_err are 0, and reads of the control register and of any scratch word return 0.
- R2: A read at byte offsets 0x0000 to 0x2FFF raises x_rd during the request cycle with x_idx = offset/4. The next cycle carries x_data on bus_rdata. Offset 0x3000 is not part of this window.
- R3: A read at byte offsets 0x6000 to 0x63FF raises y_rd with y_idx = (offset-0x6000)/4 and returns y_data one cycle later. Offset 0x6400 is outside this window.
- R4: A read at byte offsets 0xA000 to 0xDFFF raises p_rd with p_idx = (offset-0xA000)/4 and returns p_data one cycle later. Offset 0x9FFC is outside this window.
- R5: Every read request gives bus_rvalid high for exactly the following cycle. Cycles without a read leave bus_rvalid low. At most one of x_rd, y_rd and p_rd is high at a time.
- R6: A write into any memory window raises no read strobe and sets win_wr_err. The flag stays set until reset. No register changes, including the scratch word that shares the same low index bits.
- R7: Any offset outside the windows and the control register reaches a 16-word scratch file, indexed by (offset/4) mod 16. The file reads back the last value written, so 0x3000 and 0x3040 alias.
- R8: The control register at byte offset 0xFFFC reads back all 32 written bits. core_nmi follows its bit 2 and core_abort follows its bit 3, from the cycle after the write.
- R9: core_run is high exactly while control bits 0 (processor release) and 1 (DSP release) are both 1.
- R10: A control write with bit 0 or bit 1 at 0 gives core_reset high for the single following cycle, on every such write.
- R11: A control write with bits 0 and 1 both 1 gives core_boot high for the single following cycle, but only if bits 0 and 1 were not both 1 before the write. A repeated release gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset within the region |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after the request) |
| bus_rdata | output | 32 | Read data |
| x_rd | output | 1 | X space read strobe |
| x_idx | output | 12 | X space word index |
| x_data | input | 32 | X space data, registered by the memory |
| y_rd | output | 1 | Y space read strobe |
| y_idx | output | 8 | Y space word index |
| y_data | input | 32 | Y space data, registered by the memory |
| p_rd | output | 1 | P space read strobe |
| p_idx | output | 12 | P space word index |
| p_data | input | 32 | P space data, registered by the memory |
| core_reset | output | 1 | One-cycle DSP reset pulse |
| core_boot | output | 1 | One-cycle DSP bootstrap pulse |
| core_run | output | 1 | Both release bits set; frames may start |
| core_nmi | output | 1 | NMI level from control bit 2 |
| core_abort | output | 1 | Abort level from control bit 3 |
| win_wr_err | output | 1 | Sticky illegal-window-write flag |

## Verification
A wrong window decode shows up within the request cycle: the wrong strobe is raised, or the index is off. It also shows up one cycle later as data from the wrong space or from the scratch file. The window edges at both ends are therefore read directly. A stale copy of the release bits shows up one cycle after a control write, as a missing, extra or repeated bootstrap pulse, or as core_run at the wrong level. A write that reaches storage it should not touch only shows up later, so the aliased scratch word is read back after every illegal window write.

// File: rtl/dsp_mmio_front.sv
module dsp_mmio_front #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int X_BASE    = 'h0000,
  parameter int X_WORDS   = 'hC00,
  parameter int Y_BASE    = 'h6000,
  parameter int Y_WORDS   = 'h100,
  parameter int P_BASE    = 'hA000,
  parameter int P_WORDS   = 'h1000,
  parameter int CTRL_OFF  = 'hFFFC,
  parameter int SCR_WORDS = 16,
  localparam int XIW = $clog2(X_WORDS),
  localparam int YIW = $clog2(Y_WORDS),
  localparam int PIW = $clog2(P_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic           bus_rvalid,
  output logic [DW-1:0]  bus_rdata,
  output logic           x_rd,
  output logic [XIW-1:0] x_idx,
  input  logic [DW-1:0]  x_data,
  output logic           y_rd,
  output logic [YIW-1:0] y_idx,
  input  logic [DW-1:0]  y_data,
  output logic           p_rd,
  output logic [PIW-1:0] p_idx,
  input  logic [DW-1:0]  p_data,
  output logic           core_reset,
  output logic           core_boot,
  output logic           core_run,
  output logic           core_nmi,
  output logic           core_abort,
  output logic           win_wr_err
);
  localparam int WIW = AW - 2;
  localparam int SIW = $clog2(SCR_WORDS);
  localparam int B_PROC = 0;
  localparam int B_DSP  = 1;
  localparam int B_NMI  = 2;
  localparam int B_ABRT = 3;
  localparam logic [WIW-1:0] XB_W = WIW'(X_BASE >> 2);
  localparam logic [WIW-1:0] XE_W = WIW'((X_BASE >> 2) + X_WORDS);
  localparam logic [WIW-1:0] YB_W = WIW'(Y_BASE >> 2);
  localparam logic [WIW-1:0] YE_W = WIW'((Y_BASE >> 2) + Y_WORDS);
  localparam logic [WIW-1:0] PB_W = WIW'(P_BASE >> 2);
  localparam logic [WIW-1:0] PE_W = WIW'((P_BASE >> 2) + P_WORDS);
  localparam logic [WIW-1:0] CT_W = WIW'(CTRL_OFF >> 2);

  typedef enum logic [1:0] {SRC_REG, SRC_X, SRC_Y, SRC_P} src_e;

  logic [WIW-1:0] widx, xoff, yoff, poff;
  logic           in_x, in_y, in_p, in_win, hit_ctrl, rd_req, wr_req;
  logic [DW-1:0]  ctrl_q, reg_q, reg_rd;
  logic [DW-1:0]  scr [SCR_WORDS];
  src_e           src_q;

  assign widx     = bus_addr[AW-1:2];
  assign in_x     = (widx >= XB_W) && (widx < XE_W);
  assign in_y     = (widx >= YB_W) && (widx < YE_W);
  assign in_p     = (widx >= PB_W) && (widx < PE_W);
  assign in_win   = in_x || in_y || in_p;
  assign hit_ctrl = (widx == CT_W);
  assign rd_req   = bus_valid && !bus_write;
  assign wr_req   = bus_valid && bus_write;

  assign xoff  = widx - XB_W;
  assign yoff  = widx - YB_W;
  assign poff  = widx - PB_W;
  assign x_idx = xoff[XIW-1:0];
  assign y_idx = yoff[YIW-1:0];
  assign p_idx = poff[PIW-1:0];
  assign x_rd  = rd_req && in_x;
  assign y_rd  = rd_req && in_y;
  assign p_rd  = rd_req && in_p;

  assign reg_rd = hit_ctrl ? ctrl_q : scr[widx[SIW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      src_q      <= SRC_REG;
      reg_q      <= '0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) begin
        reg_q <= reg_rd;
        if (in_x)      src_q <= SRC_X;
        else if (in_y) src_q <= SRC_Y;
        else if (in_p) src_q <= SRC_P;
        else           src_q <= SRC_REG;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_X:   bus_rdata = x_data;
      SRC_Y:   bus_rdata = y_data;
      SRC_P:   bus_rdata = p_data;
      default: bus_rdata = reg_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      core_reset <= 1'b0;
      core_boot  <= 1'b0;
      win_wr_err <= 1'b0;
      for (int i = 0; i < SCR_WORDS; i++) scr[i] <= '0;
    end else begin
      core_reset <= 1'b0;
      core_boot  <= 1'b0;
      if (wr_req) begin
        if (in_win) begin
          win_wr_err <= 1'b1;
        end else if (hit_ctrl) begin
          ctrl_q <= bus_wdata;
          if (!(bus_wdata[B_PROC] && bus_wdata[B_DSP]))
            core_reset <= 1'b1;
          else if (!(ctrl_q[B_PROC] && ctrl_q[B_DSP]))
            core_boot <= 1'b1;
        end else begin
          scr[widx[SIW-1:0]] <= bus_wdata;
        end
      end
    end
  end

  assign core_run   = ctrl_q[B_PROC] && ctrl_q[B_DSP];
  assign core_nmi   = ctrl_q[B_NMI];
  assign core_abort = ctrl_q[B_ABRT];
endmodule

// File: rtl/dsp_mmio_front_chk.sv
module dsp_mmio_front_chk #(
  parameter int AW      = 16,
  parameter int X_BASE  = 'h0000,
  parameter int X_WORDS = 'hC00,
  parameter int Y_BASE  = 'h6000,
  parameter int Y_WORDS = 'h100,
  parameter int P_BASE  = 'hA000,
  parameter int P_WORDS = 'h1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rvalid,
  input logic          x_rd,
  input logic          y_rd,
  input logic          p_rd,
  input logic          core_reset,
  input logic          core_boot,
  input logic          core_run,
  input logic          win_wr_err
);
  int  wi;
  logic in_win;
  assign wi = int'(bus_addr >> 2);
  assign in_win = (wi >= (X_BASE >> 2) && wi < (X_BASE >> 2) + X_WORDS) ||
                  (wi >= (Y_BASE >> 2) && wi < (Y_BASE >> 2) + Y_WORDS) ||
                  (wi >= (P_BASE >> 2) && wi < (P_BASE >> 2) + P_WORDS);

  assert_read_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);
  assert_no_spurious_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({x_rd, y_rd, p_rd}));
  assert_write_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write) |-> !(x_rd || y_rd || p_rd));
  assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && in_win) |=> win_wr_err);
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr_err |=> win_wr_err);
  assert_run_rise_boot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> core_boot);
  assert_reset_not_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> !core_run);
  assert_pulses_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_reset && core_boot));
  assert_boot_first_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    core_boot |-> (core_run && !$past(core_run)));
endmodule

bind dsp_mmio_front dsp_mmio_front_chk #(
  .AW(AW), .X_BASE(X_BASE), .X_WORDS(X_WORDS), .Y_BASE(Y_BASE),
  .Y_WORDS(Y_WORDS), .P_BASE(P_BASE), .P_WORDS(P_WORDS)
) i_chk (.*);

// File: tb/test_dsp_mmio_front.sv
`timescale 1ns/1ps
module test_dsp_mmio_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        x_rd, y_rd, p_rd;
  logic [11:0] x_idx;
  logic [7:0]  y_idx;
  logic [11:0] p_idx;
  logic [31:0] x_data = '0, y_data = '0, p_data = '0;
  logic        core_reset, core_boot, core_run, core_nmi, core_abort, win_wr_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  dsp_mmio_front i_dsp_mmio_front (.*);

  always @(posedge clk) begin
    if (x_rd) x_data <= 32'hA000_0000 | 32'(x_idx);
    if (y_rd) y_data <= 32'hB000_0000 | 32'(y_idx);
    if (p_rd) p_data <= 32'hC000_0000 | 32'(p_idx);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected rvalid", 32'd1, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  // strb: {x,y,p}; idx checked on the strobed port
  task automatic rd(input logic [15:0] a, input logic [31:0] e, input logic [2:0] strb,
                    input logic [11:0] idx, input string t);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    chk({x_rd, y_rd, p_rd} == strb, {t, " strobe"}, 32'({x_rd, y_rd, p_rd}), 32'(strb));
    if (strb[2]) chk(x_idx == idx, {t, " index"}, 32'(x_idx), 32'(idx));
    if (strb[1]) chk(y_idx == idx[7:0], {t, " index"}, 32'(y_idx), 32'(idx));
    if (strb[0]) chk(p_idx == idx, {t, " index"}, 32'(p_idx), 32'(idx));
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    chk({x_rd, y_rd, p_rd} == 3'b000, "R6 no strobe on write", 32'({x_rd, y_rd, p_rd}), 32'd0);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic ctl(input logic [31:0] d, input bit e_rst, input bit e_boot, input bit e_run);
    wr(16'hFFFC, d);
    chk(core_reset == e_rst, "R10 reset pulse", 32'(core_reset), 32'(e_rst));
    chk(core_boot == e_boot, "R11 boot pulse", 32'(core_boot), 32'(e_boot));
    chk(core_run == e_run, "R9 run level", 32'(core_run), 32'(e_run));
    @(negedge clk);
    chk(!core_reset && !core_boot, "R10 R11 single-cycle pulse", 32'({core_reset, core_boot}), 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({core_reset, core_boot, core_run, core_nmi, core_abort, win_wr_err} == 6'b0,
        "R1 reset outputs", 32'({core_reset, core_boot, core_run, core_nmi, core_abort, win_wr_err}), 32'd0);
    rd(16'hFFFC, 32'h0, 3'b000, 12'h0, "R1 control after reset");
    rd(16'h3004, 32'h0, 3'b000, 12'h0, "R1 scratch after reset");
    // R2
    rd(16'h0000, 32'hA000_0000, 3'b100, 12'h000, "R2 X first");
    rd(16'h0124, 32'hA000_0049, 3'b100, 12'h049, "R2 X middle");
    rd(16'h2FFC, 32'hA000_0BFF, 3'b100, 12'hBFF, "R2 X last");
    rd(16'h3000, 32'h0, 3'b000, 12'h0, "R2 X end excluded");
    // R3
    rd(16'h6000, 32'hB000_0000, 3'b010, 12'h000, "R3 Y first");
    rd(16'h63FC, 32'hB000_00FF, 3'b010, 12'h0FF, "R3 Y last");
    rd(16'h6400, 32'h0, 3'b000, 12'h0, "R3 Y end excluded");
    // R4
    rd(16'h9FFC, 32'h0, 3'b000, 12'h0, "R4 below P excluded");
    rd(16'hA000, 32'hC000_0000, 3'b001, 12'h000, "R4 P first");
    rd(16'hDFFC, 32'hC000_0FFF, 3'b001, 12'hFFF, "R4 P last");
    // R5 back-to-back reads from different spaces
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 16'h0008;
    exp_q.push_back(32'hA000_0002); tag_q.push_back("R5 back-to-back X");
    @(negedge clk);
    bus_addr = 16'hA010;
    exp_q.push_back(32'hC000_0004); tag_q.push_back("R5 back-to-back P");
    @(negedge clk);
    bus_valid = 1'b0;
    @(negedge clk);
    chk(!bus_rvalid, "R5 rvalid drops", 32'(bus_rvalid), 32'd0);
    // R7
    wr(16'h3000, 32'h1234_5678);
    wr(16'h4004, 32'hCAFE_F00D);
    rd(16'h3000, 32'h1234_5678, 3'b000, 12'h0, "R7 scratch readback");
    rd(16'h3040, 32'h1234_5678, 3'b000, 12'h0, "R7 scratch alias");
    rd(16'h4004, 32'hCAFE_F00D, 3'b000, 12'h0, "R7 second scratch word");
    // R6
    chk(!win_wr_err, "R6 no error before illegal write", 32'(win_wr_err), 32'd0);
    wr(16'h6000, 32'hDEAD_BEEF);
    chk(win_wr_err, "R6 error set", 32'(win_wr_err), 32'd1);
    rd(16'h3000, 32'h1234_5678, 3'b000, 12'h0, "R6 aliased scratch untouched");
    wr(16'h0010, 32'h0000_0003);
    rd(16'hFFFC, 32'h0, 3'b000, 12'h0, "R6 control untouched");
    chk(!core_run, "R6 run untouched", 32'(core_run), 32'd0);
    rd(16'h0010, 32'hA000_0004, 3'b100, 12'h004, "R6 window still readable");
    wr(16'h3008, 32'h5);
    chk(win_wr_err, "R6 error sticky", 32'(win_wr_err), 32'd1);
    // R8 to R11
    ctl(32'h0000_0003, 1'b0, 1'b1, 1'b1);
    ctl(32'h0000_000F, 1'b0, 1'b0, 1'b1);
    chk(core_nmi && core_abort, "R8 nmi abort levels", 32'({core_nmi, core_abort}), 32'd3);
    rd(16'hFFFC, 32'h0000_000F, 3'b000, 12'h0, "R8 control readback");
    ctl(32'h0000_0002, 1'b1, 1'b0, 1'b0);
    chk(!core_nmi && !core_abort, "R8 nmi abort cleared", 32'({core_nmi, core_abort}), 32'd0);
    ctl(32'h0000_0000, 1'b1, 1'b0, 1'b0);
    ctl(32'h0000_0001, 1'b1, 1'b0, 1'b0);
    ctl(32'h0000_0003, 1'b0, 1'b1, 1'b1);
    ctl(32'hFFFF_FFF7, 1'b0, 1'b0, 1'b1);
    rd(16'hFFFC, 32'hFFFF_FFF7, 3'b000, 12'h0, "R8 full-width readback");
    chk(core_nmi && !core_abort, "R8 bit levels", 32'({core_nmi, core_abort}), 32'd2);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule